// File: doc/BRIEF.md
# Keypad Event Interrupt Unit

This block sits beside a key matrix scanner and a hook switch. Each clock it samples the scanner's key-down flag, the row and column of the key, and the hook switch level. It keeps a registered copy of these, and turns their changes into three interrupt events: a key going down, a key coming up, and the hook switch changing level in either direction. Every event has an enable bit, and an event is recorded in its pending bit only when that enable bit is already 1 on the cycle the event happens. A single level interrupt output is the OR of the pending bits and stays high until software clears them by writing ones.

Software reaches the block through a plain register bus: a word address, a write strobe, write data and combinational read data. The word at address 0 is a read-only status snapshot, address 1 holds the pending bits (write 1 to clear) and address 2 holds the enable bits. The bus has no handshake: a write takes effect on the clock edge where the strobe is high. A software reset input from the surrounding controller restarts edge detection without disturbing the pending or enable state.

Top module: `keypad_irq_unit`

## Requirements
- R1: Reading address 0 returns the status word: bit 7 = key down flag (1 = pressed), bit 6 = hook level, bits 5:3 = row, bits 2:0 = column, bits 31:8 = 0, all as sampled on the previous clock edge; row and column hold the last key seen down and read as 0 while the flag is 0.
- R2: Writes to address 0 change nothing: status, pending and enable read back as before.
- R3: A 0-to-1 change of the key down input sets pending bit 0 if enable bit 0 is 1.
- R4: A 1-to-0 change of the key down input sets pending bit 1 if enable bit 1 is 1.
- R5: Any change of the hook input sets pending bit 2 if enable bit 2 is 1.
- R6: An event whose enable bit is 0 is dropped; enabling the bit later does not make it appear.
- R7: Writing address 1 clears every pending bit whose write data bit is 1 and leaves bits written with 0 unchanged.
- R8: When an enabled event and a write-1 clear hit the same pending bit in one cycle, the bit stays set.
- R9: The interrupt output is 1 exactly when any pending bit is 1 and stays high until software clears all of them.
- R10: Address 2 holds the enable bits at positions 2:0 (bit 0 press, bit 1 release, bit 2 hook); bits 31:3 are ignored on write and read as 0.
- R11: While the software reset input is 1 no event is detected and pending and enable keep their values; the history is reloaded from the inputs, so no event follows the release.
- R12: Hardware reset (active low) clears pending, enable and history; the interrupt output is 0.
- R13: Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset from the controller; suppresses event detection |
| key_down | input | 1 | Scanner key-down flag |
| hook_lvl | input | 1 | Hook switch level |
| key_row | input | 3 | Row of the key being reported |
| key_col | input | 3 | Column of the key being reported |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
Directed patterns press and release keys at distinct row and column pairs and toggle the hook both ways with all sources enabled, which separates a rising-edge detector from a falling-edge or level detector and shows that row and column are blanked after release. The same events are then repeated with enables off and turned on afterwards, with a clear coinciding with an event on the same bit, with writes aimed at the status word and with a software reset held while inputs move, telling apart latching gates from output masks and event priority from clear priority. A long random phase with random inputs, bus writes and software resets is compared every clock against a behavioural model, catching any mismatch in the combined state.

// File: rtl/keypad_irq_pkg.sv
package keypad_irq_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned STAT_W   = 2 + 2 * IDX_W;

  localparam int unsigned SRC_PRESS   = 0;
  localparam int unsigned SRC_RELEASE = 1;
  localparam int unsigned SRC_HOOK    = 2;

  typedef struct packed {
    logic             down;
    logic             hook;
    logic [IDX_W-1:0] row;
    logic [IDX_W-1:0] col;
  } key_status_t;
endpackage

// File: rtl/keypad_edge_detect.sv
module keypad_edge_detect
  import keypad_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               key_down_i,
  input  logic               hook_i,
  input  logic [IDX_W-1:0]   row_i,
  input  logic [IDX_W-1:0]   col_i,
  output logic [NUM_SRC-1:0] ev_o,
  output key_status_t        status_o
);
  logic             key_q;
  logic             hook_q;
  logic [IDX_W-1:0] row_q;
  logic [IDX_W-1:0] col_q;

  // History: the same update in normal operation and software reset, so a
  // software reset reloads it from the live inputs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= 1'b0;
      hook_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      key_q  <= key_down_i;
      hook_q <= hook_i;
      if (key_down_i) begin
        row_q <= row_i;
        col_q <= col_i;
      end
    end
  end

  always_comb begin
    ev_o = '0;
    if (!soft_rst) begin
      ev_o[SRC_PRESS]   = key_down_i & ~key_q;
      ev_o[SRC_RELEASE] = ~key_down_i & key_q;
      ev_o[SRC_HOOK]    = hook_i ^ hook_q;
    end
  end

  always_comb begin
    status_o.down = key_q;
    status_o.hook = hook_q;
    status_o.row  = key_q ? row_q : '0;
    status_o.col  = key_q ? col_q : '0;
  end

  p_press_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(key_q) && !$past(soft_rst)) |-> $past(ev_o[SRC_PRESS]));
  p_release_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(key_q) && !$past(soft_rst)) |-> $past(ev_o[SRC_RELEASE]));
  p_hook_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hook_q) && !$past(soft_rst)) |-> $past(ev_o[SRC_HOOK]));
  p_soft_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (ev_o == '0));
endmodule

// File: rtl/keypad_irq_regs.sv
module keypad_irq_regs
  import keypad_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] en_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic hit;
    assign hit = ev_i[s] & en_q[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[s] <= 1'b0;
      end else if (hit) begin
        pend_q[s] <= 1'b1;
      end else if (clr_i[s]) begin
        pend_q[s] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[s] <= 1'b0;
      end else if (en_wr_i) begin
        en_q[s] <= en_wdata_i[s];
      end
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_i & en_q)) |=> (($past(ev_i & en_q) & ~pend_q) == '0));
  p_masked_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((pend_q & $past(clr_i & ~(ev_i & en_q))) == '0));
endmodule

// File: rtl/keypad_bus_read.sv
module keypad_bus_read
  import keypad_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned STAT_OFS = 0,
  parameter int unsigned PEND_OFS = 1,
  parameter int unsigned EN_OFS   = 2
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  key_status_t        status_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFS);

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_STAT) begin
      rdata_o[STAT_W-1:0] = status_i;
    end else if (addr_i == A_PEND) begin
      rdata_o[NUM_SRC-1:0] = pend_i;
    end else if (addr_i == A_EN) begin
      rdata_o[NUM_SRC-1:0] = en_i;
    end
  end
endmodule

// File: rtl/keypad_irq_unit.sv
module keypad_irq_unit
  import keypad_irq_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned STAT_OFS = 0,
  parameter int unsigned PEND_OFS = 1,
  parameter int unsigned EN_OFS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              key_down,
  input  logic              hook_lvl,
  input  logic [2:0]        key_row,
  input  logic [2:0]        key_col,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFS);

  logic [NUM_SRC-1:0] ev;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] clr;
  logic               en_wr;
  key_status_t        status;

  assign clr   = (bus_wr && bus_addr == A_PEND) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign en_wr = bus_wr && bus_addr == A_EN;

  keypad_edge_detect u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .key_down_i (key_down),
    .hook_i     (hook_lvl),
    .row_i      (key_row),
    .col_i      (key_col),
    .ev_o       (ev),
    .status_o   (status)
  );

  keypad_irq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev),
    .clr_i      (clr),
    .en_wr_i    (en_wr),
    .en_wdata_i (bus_wdata[NUM_SRC-1:0]),
    .pend_o     (pend),
    .en_o       (en)
  );

  keypad_bus_read #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .PEND_OFS (PEND_OFS),
    .EN_OFS   (EN_OFS)
  ) u_read (
    .addr_i   (bus_addr),
    .status_i (status),
    .pend_i   (pend),
    .en_i     (en),
    .rdata_o  (bus_rdata)
  );

  assign irq = |pend;

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_wr && bus_addr == A_PEND)) |=> irq);
  p_soft_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !bus_wr) |=> ($stable(pend) && $stable(en)));
endmodule

// File: tb/test_keypad_irq_unit.sv
module test_keypad_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        key_down = 1'b0;
  logic        hook_lvl = 1'b0;
  logic [2:0]  key_row = '0;
  logic [2:0]  key_col = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model state
  bit       m_key, m_hook;
  bit [2:0] m_row, m_col, m_pend, m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_irq_unit i_keypad_irq_unit (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .key_down(key_down),
    .hook_lvl(hook_lvl), .key_row(key_row), .key_col(key_col),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic bit [31:0] mread(input bit [1:0] a);
    case (a)
      2'd0: mread = {24'd0, m_key, m_hook, m_key ? m_row : 3'd0, m_key ? m_col : 3'd0};
      2'd1: mread = {29'd0, m_pend};
      2'd2: mread = {29'd0, m_en};
      default: mread = 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit [2:0] ev, clr;
    if (!rst_n) begin
      m_key = 0; m_hook = 0; m_row = 0; m_col = 0; m_pend = 0; m_en = 0;
    end else begin
      ev = 3'd0;
      if (!soft_rst) begin
        ev[0] = key_down & ~m_key;
        ev[1] = ~key_down & m_key;
        ev[2] = hook_lvl ^ m_hook;
      end
      clr = (bus_wr && bus_addr == 2'd1) ? bus_wdata[2:0] : 3'd0;
      m_pend = (m_pend & ~clr) | (ev & m_en);
      if (bus_wr && bus_addr == 2'd2) m_en = bus_wdata[2:0];
      m_key = key_down;
      m_hook = hook_lvl;
      if (key_down) begin m_row = key_row; m_col = key_col; end
    end
  end

  function automatic string tag_of(input bit [1:0] a);
    case (a)
      2'd0: tag_of = "R1";
      2'd1: tag_of = "R7";
      2'd2: tag_of = "R10";
      default: tag_of = "R13";
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (irq !== (|m_pend)) begin
        miscompares++;
        $display("FAIL R9 irq act=%0b exp=%0b t=%0t", irq, |m_pend, $time);
      end
      vectors++;
      if (bus_rdata !== mread(bus_addr)) begin
        miscompares++;
        $display("FAIL %s rdata@%0d act=%h exp=%h t=%0t", tag_of(bus_addr),
                 bus_addr, bus_rdata, mread(bus_addr), $time);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 irq in reset", {31'd0, irq}, 32'd0);
    rd(2'd1, d); chk("R12 pending in reset", d, 32'd0);
    rd(2'd2, d); chk("R12 enable in reset", d, 32'd0);
    rst_n = 1'b1;
    cyc();

    wr(2'd2, 32'd7);
    rd(2'd2, d); chk("R10 enable readback", d, 32'd7);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R10 reserved enable bits", d, 32'd7);

    key_row = 3'd5; key_col = 3'd3; key_down = 1'b1;
    cyc();
    rd(2'd1, d); chk("R3 press pending", d, 32'd1);
    chk("R9 irq on pending", {31'd0, irq}, 32'd1);
    rd(2'd0, d); chk("R1 status pressed", d, 32'h0000_00AB);

    wr(2'd1, 32'd0);
    rd(2'd1, d); chk("R7 write 0 keeps", d, 32'd1);
    wr(2'd1, 32'd1);
    rd(2'd1, d); chk("R7 write 1 clears", d, 32'd0);
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);

    key_down = 1'b0;
    cyc();
    rd(2'd1, d); chk("R4 release pending", d, 32'd2);
    rd(2'd0, d); chk("R1 row/col blank", d, 32'd0);

    hook_lvl = 1'b1;
    cyc();
    rd(2'd1, d); chk("R5 hook pending", d, 32'd6);
    rd(2'd0, d); chk("R1 hook status", d, 32'h40);
    wr(2'd1, 32'd6);

    wr(2'd2, 32'd0);
    key_row = 3'd1; key_col = 3'd1; key_down = 1'b1;
    cyc();
    rd(2'd1, d); chk("R6 disabled press", d, 32'd0);
    wr(2'd2, 32'd1);
    rd(2'd1, d); chk("R6 late enable", d, 32'd0);
    wr(2'd2, 32'd7);

    key_down = 1'b0;
    wr(2'd1, 32'd2);
    rd(2'd1, d); chk("R8 event beats clear", d, 32'd2);

    key_row = 3'd2; key_col = 3'd7; key_down = 1'b1;
    cyc();
    rd(2'd1, d); chk("R3 second press", d, 32'd3);
    wr(2'd0, 32'd0);
    rd(2'd0, d); chk("R2 status unchanged", d, 32'h0000_00D7);
    rd(2'd1, d); chk("R2 pending unchanged", d, 32'd3);
    rd(2'd2, d); chk("R2 enable unchanged", d, 32'd7);

    soft_rst = 1'b1; hook_lvl = 1'b0; key_down = 1'b0;
    cyc(); cyc();
    soft_rst = 1'b0;
    cyc();
    rd(2'd1, d); chk("R11 pending kept", d, 32'd3);
    rd(2'd2, d); chk("R11 enable kept", d, 32'd7);
    rd(2'd0, d); chk("R11 history reloaded", d, 32'd0);
    rd(2'd3, d); chk("R13 unmapped read", d, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      key_down  = ($urandom_range(0, 3) == 0) ? ~key_down : key_down;
      hook_lvl  = ($urandom_range(0, 7) == 0) ? ~hook_lvl : hook_lvl;
      key_row   = 3'($urandom);
      key_col   = 3'($urandom);
      soft_rst  = ($urandom_range(0, 15) == 0);
      bus_addr  = 2'($urandom);
      bus_wr    = ($urandom_range(0, 3) == 0);
      bus_wdata = $urandom;
      cyc();
    end
    bus_wr = 1'b0; soft_rst = 1'b0;

    wr(2'd2, 32'd7);
    hook_lvl = ~hook_lvl;
    cyc();
    rst_n = 1'b0;
    #1;
    chk("R12 irq after reset", {31'd0, irq}, 32'd0);
    rd(2'd1, d); chk("R12 pending cleared", d, 32'd0);
    rd(2'd2, d); chk("R12 enable cleared", d, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule